// File: doc/BRIEF.md
# Programmable Bidirectional Port Controller

This block controls a 24-bit parallel port built from three byte-wide groups, A, B and C. Software sets each group's direction on its own. It also serves a dedicated 16-bit output word and a dedicated 16-bit input word. Software reaches everything through a byte-wide register bus with single-cycle write and read strobes. The block drives a per-pin output-enable and a per-pin output value toward external tri-state pads. It samples the pad levels through a two-flop synchronizer.

A single master enable bit gates every pin. It is cleared by reset. While it is low, no pad is driven, the output word reads as zero toward its pins, and every data read returns zero. The data latches stay writable whatever the direction and the enable. This lets software preload a group's value while the group is still an input. When the group is switched to output, that value appears on the pins in the same cycle.

Register offsets (one byte each): 0 master enable (bit 0), 1 direction bits (bit 0 group A, bit 1 group B, bit 2 group C, 1 = output), 2/3/4 data for groups A/B/C, 5/6 output word low/high byte, 7/8 input word low/high byte (read only). Read data appears on `bus_rdata` in the cycle after the read strobe.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every pad output-enable is 0, every pad output value is 0, the output word pins and their enable are 0, and offsets 0 and 1 read as 0 (all groups inputs, port disabled).
- R2: While the master enable (offset 0 bit 0) is 0, no pad output-enable is asserted, whatever the direction bits hold, and group data reads (offsets 2 to 4) return 0.
- R3: While the master enable is 1, the eight output-enables of a group are all 1 exactly when that group's direction bit (offset 1, bit 0 = A, bit 1 = B, bit 2 = C) is 1, and all 0 otherwise.
- R4: A write to the data offset of a group set as input changes only its latch: the pad output-enables and pad output values of that group stay 0.
- R5: The cycle after a group's direction bit is set (with the port enabled), its pads drive the value last written to its latch, including a value written earlier while disabled or while the group was an input.
- R6: A read of an output group returns its latched value. A read of an input group returns the synchronized pad levels of that group's eight pins.
- R7: The output word latch is 0 after reset. Offsets 5 and 6 write its low and high bytes. Its pins and enable show the latch only while the master enable is 1, and show 0 otherwise.
- R8: Offsets 7 and 8 return the low and high bytes of the synchronized input word while the master enable is 1, and 0 while it is 0.
- R9: A pad level change reaches a read only after two clock edges. A read sampled on the second edge after the change returns the old level, and one sampled on the third returns the new level.
- R10: Reads of offsets 9 to 15 return 0. Read data is registered and appears one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| pad_in | input | 24 | Pad levels of groups A (7:0), B (15:8), C (23:16) |
| pad_oe | output | 24 | Per-pin output-enable toward the pads |
| pad_out | output | 24 | Per-pin output value toward the pads |
| din_word | input | 16 | Dedicated input word |
| dout_word | output | 16 | Dedicated output word |
| dout_oe | output | 1 | Output word enable |

## Verification
The bench builds the block with its defaults: byte-wide groups and a two-stage synchronizer. Every register offset and each of the three groups is therefore reached through the real register map. The two-stage depth also makes the exact edge at which a pad change becomes readable a fixed, checkable number. The sequence preloads latches while the port is disabled and while a group is an input. It then switches directions and the enable, and compares pad drive and readback against values computed from the register semantics alone.

// File: rtl/gpio_bank_pkg.sv
// Shared definitions for the bidirectional port controller.
// Assumes a byte-wide register bus with a 4-bit offset space.
package gpio_bank_pkg;
    localparam int unsigned REG_ADDR_W = 4;
    localparam int unsigned NUM_GROUPS = 3;
    localparam int unsigned AUX_BYTES  = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        OFS_CTRL   = 4'd0,
        OFS_DIR    = 4'd1,
        OFS_GRP_A  = 4'd2,
        OFS_GRP_B  = 4'd3,
        OFS_GRP_C  = 4'd4,
        OFS_OUT_LO = 4'd5,
        OFS_OUT_HI = 4'd6,
        OFS_IN_LO  = 4'd7,
        OFS_IN_HI  = 4'd8
    } reg_ofs_e;
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer for asynchronous pad levels.
// Assumes each bit is sampled independently; no bus coherency is implied.
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the pad level through the flop chain, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_group.sv
// One byte-wide bidirectional group: output latch, pad drive and readback.
// Assumes pin_sync is already synchronized; the latch is always writable.
module gpio_group #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [WIDTH-1:0] wdata,
    input  logic             dir_out,
    input  logic             enable,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] rd_value
);
    logic [WIDTH-1:0] latch_q;
    logic             drive;

    // Capture written data regardless of direction or enable.
    always_ff @(posedge clk) begin
        if (!rst_n)      latch_q <= '0;
        else if (wr_hit) latch_q <= wdata;
    end

    assign drive   = enable && dir_out;
    assign pad_oe  = {WIDTH{drive}};
    assign pad_out = drive ? latch_q : '0;

    // Select the readback source: latch when output, pins when input, zero when disabled.
    always_comb begin
        if (!enable)      rd_value = '0;
        else if (dir_out) rd_value = latch_q;
        else              rd_value = pin_sync;
    end
endmodule

// File: rtl/gpio_out_word.sv
// Dedicated output word: byte-writable latch gated by the master enable.
// Assumes the word is exactly two bus bytes wide.
module gpio_out_word #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              enable,
    output logic [WORD_W-1:0] word_q,
    output logic [WORD_W-1:0] dout,
    output logic              dout_oe
);
    // Update the addressed byte of the latch; cleared to zero by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            if (wr_lo) word_q[BYTE_W-1:0]      <= wdata;
            if (wr_hi) word_q[WORD_W-1:BYTE_W] <= wdata;
        end
    end

    assign dout    = enable ? word_q : '0;
    assign dout_oe = enable;
endmodule

// File: rtl/gpio_bank_ctrl.sv
// Top of the bidirectional port controller: control registers, three
// direction-programmable groups, a dedicated output and input word, and a
// registered read mux. Assumes a single clock domain for the register bus.
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int GROUP_W     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [REG_ADDR_W-1:0]         bus_addr,
    input  logic [GROUP_W-1:0]            bus_wdata,
    output logic [GROUP_W-1:0]            bus_rdata,
    input  logic [NUM_GROUPS*GROUP_W-1:0] pad_in,
    output logic [NUM_GROUPS*GROUP_W-1:0] pad_oe,
    output logic [NUM_GROUPS*GROUP_W-1:0] pad_out,
    input  logic [AUX_BYTES*GROUP_W-1:0]  din_word,
    output logic [AUX_BYTES*GROUP_W-1:0]  dout_word,
    output logic                          dout_oe
);
    localparam int PORT_W   = NUM_GROUPS * GROUP_W;
    localparam int AUX_W    = AUX_BYTES * GROUP_W;
    localparam int GRP_BASE = int'(OFS_GRP_A);

    logic                  enable_q;
    logic [NUM_GROUPS-1:0] dir_q;
    logic [PORT_W-1:0]     pad_sync;
    logic [AUX_W-1:0]      din_sync;
    logic [AUX_W-1:0]      out_word_q;
    logic [GROUP_W-1:0]    grp_rd [NUM_GROUPS];
    logic [GROUP_W-1:0]    rd_next;

    // Hold the master enable and the direction bits; both clear at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
            dir_q    <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFS_CTRL) enable_q <= bus_wdata[0];
            if (bus_addr == OFS_DIR)  dir_q    <= bus_wdata[NUM_GROUPS-1:0];
        end
    end

    gpio_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_pad_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
    );

    gpio_sync #(.WIDTH(AUX_W), .STAGES(SYNC_STAGES)) u_din_sync (
        .clk(clk), .rst_n(rst_n), .d(din_word), .q(din_sync)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        gpio_group #(.WIDTH(GROUP_W)) u_group (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (bus_wr && (bus_addr == REG_ADDR_W'(GRP_BASE + g))),
            .wdata   (bus_wdata),
            .dir_out (dir_q[g]),
            .enable  (enable_q),
            .pin_sync(pad_sync[g*GROUP_W +: GROUP_W]),
            .pad_oe  (pad_oe[g*GROUP_W +: GROUP_W]),
            .pad_out (pad_out[g*GROUP_W +: GROUP_W]),
            .rd_value(grp_rd[g])
        );
    end

    gpio_out_word #(.BYTE_W(GROUP_W)) u_out_word (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_lo  (bus_wr && (bus_addr == OFS_OUT_LO)),
        .wr_hi  (bus_wr && (bus_addr == OFS_OUT_HI)),
        .wdata  (bus_wdata),
        .enable (enable_q),
        .word_q (out_word_q),
        .dout   (dout_word),
        .dout_oe(dout_oe)
    );

    // Choose the read value for the addressed offset; data offsets read zero when disabled.
    always_comb begin
        rd_next = '0;
        case (bus_addr)
            OFS_CTRL:   rd_next = GROUP_W'(enable_q);
            OFS_DIR:    rd_next = GROUP_W'(dir_q);
            OFS_OUT_LO: rd_next = enable_q ? out_word_q[GROUP_W-1:0] : '0;
            OFS_OUT_HI: rd_next = enable_q ? out_word_q[AUX_W-1:GROUP_W] : '0;
            OFS_IN_LO:  rd_next = enable_q ? din_sync[GROUP_W-1:0] : '0;
            OFS_IN_HI:  rd_next = enable_q ? din_sync[AUX_W-1:GROUP_W] : '0;
            default:    rd_next = '0;
        endcase
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (bus_addr == REG_ADDR_W'(GRP_BASE + g)) rd_next = grp_rd[g];
        end
    end

    // Register the read data one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
// Property checker for the port controller, attached by bind.
// Assumes the default map: enable at offset 0, data from offset 2.
module gpio_bank_ctrl_chk
    import gpio_bank_pkg::*;
#(
    parameter int GROUP_W = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_rd,
    input logic [REG_ADDR_W-1:0]         bus_addr,
    input logic [GROUP_W-1:0]            bus_rdata,
    input logic                          enable_q,
    input logic [NUM_GROUPS-1:0]         dir_q,
    input logic [NUM_GROUPS*GROUP_W-1:0] pad_oe,
    input logic [NUM_GROUPS*GROUP_W-1:0] pad_out,
    input logic [AUX_BYTES*GROUP_W-1:0]  dout_word,
    input logic                          dout_oe
);
    // R1: right after reset release nothing is driven
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && dout_oe == 1'b0 && dout_word == '0));

    // R2: disabled port drives no pad
    assert_oe_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_q |-> (pad_oe == '0 && pad_out == '0));

    // R3: each group's enables follow its direction bit as a whole byte
    assert_oe_by_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
        enable_q |-> (pad_oe == {{GROUP_W{dir_q[2]}}, {GROUP_W{dir_q[1]}}, {GROUP_W{dir_q[0]}}}));

    // R7: output word pins are zero whenever their enable is low
    assert_dout_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> dout_word == '0);

    // R8: data reads issued while disabled return zero
    assert_read_zero_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !enable_q && bus_addr >= REG_ADDR_W'(2)) |=> bus_rdata == '0);

    // R10: unmapped offsets read as zero
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr > REG_ADDR_W'(8)) |=> bus_rdata == '0);
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.GROUP_W(GROUP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .enable_q (enable_q),
    .dir_q    (dir_q),
    .pad_oe   (pad_oe),
    .pad_out  (pad_out),
    .dout_word(dout_word),
    .dout_oe  (dout_oe)
);

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [23:0] pad_in = 24'hA55A3C;
    logic [23:0] pad_oe;
    logic [23:0] pad_out;
    logic [15:0] din_word = 16'hBEEF;
    logic [15:0] dout_word;
    logic        dout_oe;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    bit rd_issued = 1'b0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    gpio_bank_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .din_word(din_word), .dout_word(dout_word), .dout_oe(dout_oe)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: issue a read and push its expected value into the scoreboard.
    task automatic do_read(logic [3:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic flush();
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: note reads at the edge, compare their data at the next falling edge.
    always @(posedge clk) rd_issued <= bus_rd;
    always @(negedge clk) begin
        if (rd_issued && exp_q.size() > 0) begin
            check(tag_q.pop_front(), 32'(bus_rdata), 32'(exp_q.pop_front()));
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pad_oe", 32'(pad_oe), 32'h0);
        check("R1 pad_out", 32'(pad_out), 32'h0);
        check("R1 dout_word", 32'(dout_word), 32'h0);
        check("R1 dout_oe", 32'(dout_oe), 32'h0);
        do_read(4'd0, 8'h00, "R1 enable reg");
        do_read(4'd1, 8'h00, "R1 dir reg");
        do_read(4'd2, 8'h00, "R2 group A read disabled");
        do_read(4'd7, 8'h00, "R8 input low disabled");
        flush();

        // Preload while disabled
        do_write(4'd1, 8'h01);
        do_write(4'd2, 8'h5A);
        check("R2 pad_oe disabled", 32'(pad_oe), 32'h0);
        do_write(4'd5, 8'h34);
        do_write(4'd6, 8'h12);
        check("R7 dout gated", 32'(dout_word), 32'h0);

        do_write(4'd0, 8'h01);
        check("R3 pad_oe group A only", 32'(pad_oe), 32'h0000FF);
        check("R5 preloaded A drives", 32'(pad_out[7:0]), 32'h5A);
        check("R7 dout_oe", 32'(dout_oe), 32'h1);
        check("R7 dout_word", 32'(dout_word), 32'h1234);

        do_write(4'd3, 8'hC3);
        check("R4 B oe stays off", 32'(pad_oe[15:8]), 32'h0);
        check("R4 B out stays off", 32'(pad_out[15:8]), 32'h0);
        do_read(4'd3, 8'h5A, "R6 input B pins");
        do_read(4'd2, 8'h5A, "R6 output A latch");
        do_read(4'd7, 8'hEF, "R8 input low");
        do_read(4'd8, 8'hBE, "R8 input high");
        do_read(4'd5, 8'h34, "R7 out low readback");
        do_read(4'd6, 8'h12, "R7 out high readback");
        do_read(4'd0, 8'h01, "R1 enable readback");
        do_read(4'd9, 8'h00, "R10 offset 9");
        do_read(4'd15, 8'h00, "R10 offset 15");
        flush();

        do_write(4'd1, 8'h03);
        check("R3 pad_oe A and B", 32'(pad_oe), 32'h00FFFF);
        check("R5 B drives preload", 32'(pad_out[15:8]), 32'hC3);
        do_read(4'd3, 8'hC3, "R6 output B latch");
        flush();

        // Synchronizer latency on group C (input)
        @(negedge clk);
        pad_in[23:16] = 8'h3C;
        do_read(4'd4, 8'hA5, "R9 old level after two edges");
        do_read(4'd4, 8'h3C, "R9 new level after three edges");
        flush();

        do_write(4'd0, 8'h00);
        check("R2 pad_oe off when disabled", 32'(pad_oe), 32'h0);
        check("R7 dout gated again", 32'(dout_word), 32'h0);
        check("R7 dout_oe low", 32'(dout_oe), 32'h0);
        do_read(4'd3, 8'h00, "R2 group B read disabled");
        do_read(4'd8, 8'h00, "R8 input high disabled");
        do_read(4'd1, 8'h03, "R1 dir still readable");
        flush();

        do_write(4'd0, 8'h01);
        check("R5 latches kept over disable", 32'(pad_out[15:0]), 32'hC35A);
        check("R3 oe restored", 32'(pad_oe), 32'h00FFFF);
        flush();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule